// File: doc/BRIEF.md
# Sensor Pixel Region and Colour Tagger

This block runs beside the pixel stream of an interline image sensor and tags each sample of the current output line. A line-start strobe marks the first sample of a line, and the block then counts samples on every clock. It tags each sample by region: horizontal dummy, optical black, effective, active, or blanking. Effective and active samples also get their Bayer colour, and every sample gets a channel-select bit that steers it to either the green path or the red/blue path.

The sensor line number and a field bit are captured with the line-start strobe. The vertical region and the colour phase of the line come from these captured values. A black-level-valid flag marks the samples that a downstream clamp may average. Each tag appears on the outputs one clock after its sample was presented. Every width and boundary is a parameter, and the defaults describe a 1688 by 1248 cell array with 28 dummy samples ahead of each line.

Top module: `pxtag_top`

## Requirements
- R1: During and right after synchronous reset the outputs read region 0 (blanking), colour 0 (none), channel-select 0 and black-level-valid 0.
- R2: The sample presented with the line-start strobe is sample 0. Samples 0 to 27 get region code 1 (dummy), and each tag appears on the outputs exactly one clock after its sample.
- R3: On an effective line, samples 28 to 31 are front black (region 2), samples 32 to 1667 are effective (region 3) or active (region 4), and samples 1668 to 1715 are rear black (region 2).
- R4: Lines 0 to 9 and lines 1246 to 1247 are black lines: every non-dummy sample up to 1715 gets region 2. On a line number of 1248 or higher, every non-dummy sample gets region 0.
- R5: A sample gets region 4 (active) when its effective column, counted from sample 32, is in 8 to 1627 and its effective row, counted from line 10, is in 8 to 1227.
- R6: Colour codes are 1 Gr, 2 R, 3 B, 4 Gb and 0 none. A line is a red line when the parity of its effective row XOR the field bit is 0. On a red line, even effective columns are R and odd ones are Gr. On other lines, even effective columns are Gb and odd ones are B. Samples outside regions 3 and 4 get colour 0.
- R7: Channel-select is 1 for R and B samples and 0 for every other sample.
- R8: Black-level-valid is 1 only for rear black samples (1668 to 1715) on effective lines 10 to 1245.
- R9: Samples after sample 1715 and before the next line start get region 0, and so do all samples before the first line start after reset.
- R10: A line-start strobe in the middle of a line restarts the count at sample 0 in that same cycle.
- R11: The line number and field bit are used only in the line-start cycle. Changes to them during the rest of the line have no effect on the tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| line_start_i | input | 1 | High with sample 0 of a line |
| line_num_i | input | LINE_W (11) | Sensor line number, captured at line start |
| field_i | input | 1 | Field bit, flips the vertical colour phase |
| region_o | output | 3 | Region code of the previous sample |
| colour_o | output | 3 | Bayer colour code of the previous sample |
| chan_rb_o | output | 1 | 1 routes the sample to the red/blue channel |
| blk_valid_o | output | 1 | Sample is usable for black-level clamping |

## Verification
The assertions check on every cycle that the tags stay consistent with each other. Black-level-valid only ever marks black samples, colour is present only on effective or active samples, and green never selects the red/blue channel. They also check that the column counter steps by one, restarts after a strobe, and holds the captured line and field for the whole line.

Only the bench's sweeps can show where the boundaries fall. These sweeps cover every line of a reduced array in both fields, with line number and field changed mid-line, plus one restart in the middle of a line. They show the exact column and row boundaries, the placement of the active window, and the Bayer phase under each field value.

// File: rtl/pxtag_pkg.sv
package pxtag_pkg;

    typedef enum logic [2:0] {
        RG_BLANK = 3'd0,
        RG_DUMMY = 3'd1,
        RG_OBLK  = 3'd2,
        RG_EFF   = 3'd3,
        RG_ACT   = 3'd4
    } region_e;

    typedef enum logic [2:0] {
        CL_NONE = 3'd0,
        CL_GR   = 3'd1,
        CL_R    = 3'd2,
        CL_B    = 3'd3,
        CL_GB   = 3'd4
    } colour_e;

    typedef enum logic [2:0] {
        HZ_BLANK,
        HZ_DUMMY,
        HZ_OBF,
        HZ_EFF,
        HZ_OBR
    } hzone_e;

    typedef enum logic [1:0] {
        VZ_OBF,
        VZ_EFF,
        VZ_OBR,
        VZ_OUT
    } vzone_e;

    typedef struct packed {
        region_e region;
        colour_e colour;
        logic    chan_rb;
        logic    blk_valid;
    } tag_t;

    localparam tag_t TAG_IDLE = '{RG_BLANK, CL_NONE, 1'b0, 1'b0};

    // Bayer phase: a red line carries R/Gr, the other line carries Gb/B.
    function automatic colour_e bayer_colour(input logic red_line, input logic even_col);
        if (red_line) return even_col ? CL_R : CL_GR;
        else          return even_col ? CL_GB : CL_B;
    endfunction

    function automatic logic is_red_blue(input colour_e c);
        return (c == CL_R) || (c == CL_B);
    endfunction

    function automatic region_e merge_region(input hzone_e h, input vzone_e v, input logic in_act);
        region_e r;
        case (h)
            HZ_DUMMY: r = RG_DUMMY;
            HZ_BLANK: r = RG_BLANK;
            default: begin
                if (v == VZ_OUT)                     r = RG_BLANK;
                else if (h != HZ_EFF || v != VZ_EFF) r = RG_OBLK;
                else                                 r = in_act ? RG_ACT : RG_EFF;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pxtag_col_tracker.sv
module pxtag_col_tracker #(
    parameter int SPAN  = 1716,
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_start,
    output logic [COL_W-1:0] cur_col
);
    localparam logic [COL_W-1:0] SAT = COL_W'(SPAN);

    logic [COL_W-1:0] col_q;

    // col_q holds the index of the sample expected in the current cycle;
    // it parks at SAT (a blanking index) until the next strobe.
    always_ff @(posedge clk) begin
        if (rst)                col_q <= SAT;
        else if (line_start)    col_q <= COL_W'(1);
        else if (col_q != SAT)  col_q <= col_q + 1'b1;
    end

    assign cur_col = line_start ? '0 : col_q;

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        line_start |=> (col_q == COL_W'(1)));

    // R2
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (!line_start && col_q != SAT) |=> (col_q == $past(col_q) + 1'b1));

    // R9
    park_chk: assert property (@(posedge clk) disable iff (rst)
        (!line_start && col_q == SAT) |=> (col_q == SAT));

endmodule

// File: rtl/pxtag_row_latch.sv
module pxtag_row_latch #(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field,
    output logic [LINE_W-1:0] cur_row,
    output logic              cur_field
);
    logic [LINE_W-1:0] row_q;
    logic              field_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q   <= '0;
            field_q <= 1'b0;
        end else if (line_start) begin
            row_q   <= line_num;
            field_q <= field;
        end
    end

    assign cur_row   = line_start ? line_num : row_q;
    assign cur_field = line_start ? field    : field_q;

    // R11
    row_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !line_start |=> (row_q == $past(row_q) && field_q == $past(field_q)));

endmodule

// File: rtl/pxtag_h_classify.sv
module pxtag_h_classify
    import pxtag_pkg::*;
#(
    parameter int DUMMY  = 28,
    parameter int HOBF   = 4,
    parameter int HEFF   = 1636,
    parameter int HOBR   = 48,
    parameter int MARG_H = 8,
    parameter int COL_W  = 11
) (
    input  logic [COL_W-1:0] col,
    output hzone_e           zone,
    output logic             in_act,
    output logic             even_col
);
    localparam int I_EFF = DUMMY + HOBF;
    localparam int I_OBR = I_EFF + HEFF;
    localparam int I_END = I_OBR + HOBR;

    localparam logic [COL_W-1:0] C_OBF = COL_W'(DUMMY);
    localparam logic [COL_W-1:0] C_EFF = COL_W'(I_EFF);
    localparam logic [COL_W-1:0] C_OBR = COL_W'(I_OBR);
    localparam logic [COL_W-1:0] C_END = COL_W'(I_END);
    localparam logic [COL_W-1:0] C_ALO = COL_W'(I_EFF + MARG_H);
    localparam logic [COL_W-1:0] C_AHI = COL_W'(I_OBR - MARG_H);

    always_comb begin
        if (col < C_OBF)      zone = HZ_DUMMY;
        else if (col < C_EFF) zone = HZ_OBF;
        else if (col < C_OBR) zone = HZ_EFF;
        else if (col < C_END) zone = HZ_OBR;
        else                  zone = HZ_BLANK;
    end

    assign in_act   = (col >= C_ALO) && (col < C_AHI);
    assign even_col = (col[0] == C_EFF[0]);

endmodule

// File: rtl/pxtag_v_classify.sv
module pxtag_v_classify
    import pxtag_pkg::*;
#(
    parameter int VOBF   = 10,
    parameter int VEFF   = 1236,
    parameter int VOBR   = 2,
    parameter int MARG_V = 8,
    parameter int LINE_W = 11
) (
    input  logic [LINE_W-1:0] row,
    input  logic              field,
    output vzone_e            zone,
    output logic              in_act,
    output logic              red_line
);
    localparam int I_OBR = VOBF + VEFF;
    localparam int I_END = I_OBR + VOBR;

    localparam logic [LINE_W-1:0] R_EFF = LINE_W'(VOBF);
    localparam logic [LINE_W-1:0] R_OBR = LINE_W'(I_OBR);
    localparam logic [LINE_W-1:0] R_END = LINE_W'(I_END);
    localparam logic [LINE_W-1:0] R_ALO = LINE_W'(VOBF + MARG_V);
    localparam logic [LINE_W-1:0] R_AHI = LINE_W'(I_OBR - MARG_V);

    logic even_row;

    always_comb begin
        if (row < R_EFF)      zone = VZ_OBF;
        else if (row < R_OBR) zone = VZ_EFF;
        else if (row < R_END) zone = VZ_OBR;
        else                  zone = VZ_OUT;
    end

    assign in_act   = (row >= R_ALO) && (row < R_AHI);
    assign even_row = (row[0] == R_EFF[0]);
    assign red_line = even_row ^ field;

endmodule

// File: rtl/pxtag_top.sv
module pxtag_top
    import pxtag_pkg::*;
#(
    parameter int DUMMY  = 28,
    parameter int HOBF   = 4,
    parameter int HEFF   = 1636,
    parameter int HOBR   = 48,
    parameter int VOBF   = 10,
    parameter int VEFF   = 1236,
    parameter int VOBR   = 2,
    parameter int MARG_H = 8,
    parameter int MARG_V = 8,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start_i,
    input  logic [LINE_W-1:0] line_num_i,
    input  logic              field_i,
    output logic [2:0]        region_o,
    output logic [2:0]        colour_o,
    output logic              chan_rb_o,
    output logic              blk_valid_o
);
    localparam int SPAN  = DUMMY + HOBF + HEFF + HOBR;
    localparam int COL_W = $clog2(SPAN + 1);

    logic [COL_W-1:0]  cur_col;
    logic [LINE_W-1:0] cur_row;
    logic              cur_field;
    hzone_e            hz;
    vzone_e            vz;
    logic              h_act, v_act, even_col, red_line;
    tag_t              nxt, tag_q;

    pxtag_col_tracker #(.SPAN(SPAN), .COL_W(COL_W)) u_col (
        .clk(clk), .rst(rst), .line_start(line_start_i), .cur_col(cur_col)
    );

    pxtag_row_latch #(.LINE_W(LINE_W)) u_row (
        .clk(clk), .rst(rst), .line_start(line_start_i),
        .line_num(line_num_i), .field(field_i),
        .cur_row(cur_row), .cur_field(cur_field)
    );

    pxtag_h_classify #(
        .DUMMY(DUMMY), .HOBF(HOBF), .HEFF(HEFF), .HOBR(HOBR),
        .MARG_H(MARG_H), .COL_W(COL_W)
    ) u_hcls (
        .col(cur_col), .zone(hz), .in_act(h_act), .even_col(even_col)
    );

    pxtag_v_classify #(
        .VOBF(VOBF), .VEFF(VEFF), .VOBR(VOBR), .MARG_V(MARG_V), .LINE_W(LINE_W)
    ) u_vcls (
        .row(cur_row), .field(cur_field), .zone(vz), .in_act(v_act), .red_line(red_line)
    );

    always_comb begin
        nxt           = TAG_IDLE;
        nxt.region    = merge_region(hz, vz, h_act && v_act);
        if (nxt.region == RG_EFF || nxt.region == RG_ACT)
            nxt.colour = bayer_colour(red_line, even_col);
        nxt.chan_rb   = is_red_blue(nxt.colour);
        nxt.blk_valid = (hz == HZ_OBR) && (vz == VZ_EFF);
    end

    always_ff @(posedge clk) begin
        if (rst) tag_q <= TAG_IDLE;
        else     tag_q <= nxt;
    end

    assign region_o    = tag_q.region;
    assign colour_o    = tag_q.colour;
    assign chan_rb_o   = tag_q.chan_rb;
    assign blk_valid_o = tag_q.blk_valid;

    // R1
    rst_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tag_q == TAG_IDLE));

    // R2
    first_dummy_chk: assert property (@(posedge clk) disable iff (rst)
        line_start_i |=> (region_o == RG_DUMMY));

    // R8
    blk_only_black_chk: assert property (@(posedge clk) disable iff (rst)
        blk_valid_o |-> (region_o == RG_OBLK));

    // R6
    colour_eff_only_chk: assert property (@(posedge clk) disable iff (rst)
        (region_o != RG_EFF && region_o != RG_ACT) |-> (colour_o == CL_NONE));

    // R7
    green_chan_chk: assert property (@(posedge clk) disable iff (rst)
        (colour_o == CL_GR || colour_o == CL_GB || colour_o == CL_NONE) |-> !chan_rb_o);

endmodule

// File: tb/pxtag_top_bench.sv
`timescale 1ns/1ps
module pxtag_top_bench;
    localparam int DUMMY = 3, HOBF = 2, HEFF = 12, HOBR = 3;
    localparam int VOBF = 2, VEFF = 8, VOBR = 1, MH = 2, MV = 2, LW = 5;
    localparam int SPAN = DUMMY + HOBF + HEFF + HOBR;
    localparam int VT   = VOBF + VEFF + VOBR;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ls = 1'b0;
    logic [LW-1:0] lnum = '0;
    logic          fld = 1'b0;
    logic [2:0]    region_o, colour_o;
    logic          chan_rb_o, blk_valid_o;

    int checks = 0, errors = 0;
    bit done = 0;
    int b_col = -1, b_row = 0, b_fld = 0;
    int e_reg = 0, e_col = 0, e_ch = 0, e_blk = 0;
    string e_rtag = "R9";
    string scen = "R9 idle";

    always #2 clk = ~clk;

    pxtag_top #(
        .DUMMY(DUMMY), .HOBF(HOBF), .HEFF(HEFF), .HOBR(HOBR),
        .VOBF(VOBF), .VEFF(VEFF), .VOBR(VOBR), .MARG_H(MH), .MARG_V(MV), .LINE_W(LW)
    ) u_pxtag_top (
        .clk(clk), .rst(rst), .line_start_i(ls), .line_num_i(lnum), .field_i(fld),
        .region_o(region_o), .colour_o(colour_o), .chan_rb_o(chan_rb_o), .blk_valid_o(blk_valid_o)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s [%s] col=%0d row=%0d: actual %0d expected %0d",
                     req, scen, b_col, b_row, got, exp);
        end
    endtask

    // Expected tags from the requirement arithmetic.
    task automatic model(input int c, input int r, input int f);
        int h, ec, er;
        bit eff_line;
        e_col = 0; e_blk = 0;
        eff_line = (r >= VOBF) && (r < VOBF + VEFF);
        if (c < 0 || c >= SPAN) begin e_reg = 0; e_rtag = "R9"; end
        else if (c < DUMMY)     begin e_reg = 1; e_rtag = "R2"; end
        else if (r >= VT)       begin e_reg = 0; e_rtag = "R4"; end
        else begin
            h = c - DUMMY;
            if (h < HOBF || h >= HOBF + HEFF) begin
                e_reg = 2; e_rtag = eff_line ? "R3" : "R4";
                if (eff_line && h >= HOBF + HEFF) e_blk = 1;
            end else if (!eff_line) begin
                e_reg = 2; e_rtag = "R4";
            end else begin
                ec = h - HOBF; er = r - VOBF;
                if (ec >= MH && ec < HEFF - MH && er >= MV && er < VEFF - MV) begin
                    e_reg = 4; e_rtag = "R5";
                end else begin
                    e_reg = 3; e_rtag = "R3";
                end
                if (((er % 2) ^ f) == 0) e_col = (ec % 2 == 0) ? 2 : 1;
                else                     e_col = (ec % 2 == 0) ? 4 : 3;
            end
        end
        e_ch = (e_col == 2 || e_col == 3) ? 1 : 0;
    endtask

    task automatic step(input bit start, input int num, input int f);
        @(negedge clk);
        check(e_rtag, int'(region_o), e_reg);
        check("R6", int'(colour_o), e_col);
        check("R7", int'(chan_rb_o), e_ch);
        check("R8", int'(blk_valid_o), e_blk);
        ls = start;
        if (start) begin
            lnum = LW'(num); fld = f[0];
            b_col = 0; b_row = num; b_fld = f;
        end else begin
            lnum = ~LW'(num); fld = ~f[0];   // R11: mid-line noise must be ignored
            if (b_col >= 0 && b_col < SPAN) b_col++;
        end
        model(b_col, b_row, b_fld);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", int'(region_o), 0);
        check("R1", int'(colour_o), 0);
        check("R1", int'(chan_rb_o), 0);
        check("R1", int'(blk_valid_o), 0);
        rst = 1'b0;
        model(-1, 0, 0);
        for (int i = 0; i < 4; i++) step(1'b0, 0, 0);

        scen = "R11 sweep";
        for (int f = 0; f < 2; f++)
            for (int r = 0; r < VT + 2; r++) begin
                step(1'b1, r, f);
                for (int k = 0; k < SPAN + 2; k++) step(1'b0, r, f);
            end

        scen = "R10 restart";
        step(1'b1, 5, 1);
        for (int k = 0; k < 7; k++) step(1'b0, 5, 1);
        step(1'b1, 6, 0);
        for (int k = 0; k < SPAN + 2; k++) step(1'b0, 6, 0);
        step(1'b0, 6, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule